// File: doc/BRIEF.md
# Power Mode Clock Controller

This block is a sequencer that picks the system clock source from the operating mode software asks for. Four settled modes exist. SLEEP has no active source beyond the slow one. DOZE runs from the low-speed oscillator, SLOW from the crystal oscillator and NORMAL from the PLL. Four transition states sit between the settled modes. Two of them start a source: the crystal-startup state and the PLL-startup state. The other two move the select away from a source before it is turned off: the leave-PLL state and the leave-crystal state.

Software drives two request bits, one for SLOW and one for NORMAL. The processor supplies a wait-for-interrupt flag and the interrupt logic supplies a wake-up pulse. Each oscillator reports readiness. Each startup also has a programmable count that ends the wait when no ready indication arrives. The block drives a two-bit clock-source select, the crystal and PLL enables, and a three-bit mode field. The select is intended for an external glitch-free clock mux, and all outputs are registered.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: Synchronous active-high reset places the block in DOZE. The mode field reads 1, the select reads 0 (low-speed oscillator), and both enables are 0. Mode codes: 0 SLEEP, 1 DOZE, 2 SLOW, 3 NORMAL, 4 crystal startup, 5 PLL startup, 6 leave PLL, 7 leave crystal. Select codes: 0 low-speed, 1 crystal, 2 PLL.
- R2: SLEEP is entered only from DOZE, and only when neither request bit is set and the wait-for-interrupt flag is high. In DOZE, any request takes precedence over wait-for-interrupt. In SLOW, wait-for-interrupt never leads to SLEEP.
- R3: In SLEEP, request bits and wait-for-interrupt have no effect, and the select and enables hold. A wake-up pulse moves the mode to DOZE on the next clock.
- R4: From DOZE, a request for either SLOW or NORMAL moves the block to crystal startup on the next clock. The crystal enable rises on that same clock while the select stays at 0.
- R5: In crystal startup, the select changes to 1 one clock after crystal-ready is seen, or after the crystal count value L has elapsed, whichever comes first. With no ready indication, the select changes L+1 clocks after entry. The mode becomes SLOW on the following clock.
- R6: In SLOW, a NORMAL request takes priority over a withdrawn SLOW request. It moves the block to PLL startup with the PLL enable rising. The select changes to 2 one clock after PLL-lock is seen or the PLL count elapses, with the same timing as R5. The mode becomes NORMAL one clock after that.
- R7: In SLOW with neither request set, the mode goes to 7. On the next clock the select goes to 0. On the clock after that, the crystal enable falls and the mode becomes DOZE.
- R8: In NORMAL with the NORMAL request withdrawn, the mode goes to 6. On the next clock the select goes to 1. On the clock after that, the PLL enable falls and the mode becomes SLOW.
- R9: The select changes only on clocks that leave the mode field in a transition state (codes 4 to 7), and never on the same clock as either enable.
- R10: Whenever the select reads 2, both enables are high. Whenever it reads 1, the crystal enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_slow | input | 1 | Request bit for crystal operation |
| req_normal | input | 1 | Request bit for PLL operation |
| cpu_wfi | input | 1 | Processor is in wait-for-interrupt |
| wake_irq | input | 1 | Wake-up interrupt, leaves SLEEP |
| xtal_ready | input | 1 | Crystal oscillator is stable |
| pll_lock | input | 1 | PLL is locked |
| cfg_xtal_cnt | input | CNT_W | Crystal startup count limit |
| cfg_pll_cnt | input | CNT_W | PLL startup count limit |
| clk_sel_o | output | 2 | Clock source select: 0 low-speed, 1 crystal, 2 PLL |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| mode_o | output | 3 | Current mode or transition state code |

## Verification
The hardest situation to reach is the exact cycle on which a startup ends. Reaching it needs the count limit and the arrival time of the ready indication to be placed against each other. The bench therefore sweeps the crystal and PLL count limits over small values with no ready input. It then fixes a large limit and raises the ready input after each delay from 0 to 3 clocks, and compares the measured clocks to the switch against L+1 or delay+1. SLEEP is reached only through a walk that first leaves SLOW while wait-for-interrupt is high. That walk then holds requests high inside SLEEP before the wake-up pulse.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    M_SLEEP      = 3'd0,
    M_DOZE       = 3'd1,
    M_SLOW       = 3'd2,
    M_NORMAL     = 3'd3,
    M_XTAL_UP    = 3'd4,
    M_PLL_UP     = 3'd5,
    M_LEAVE_PLL  = 3'd6,
    M_LEAVE_XTAL = 3'd7
  } pmode_e;

  typedef enum logic [1:0] {
    SRC_LOSC = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2
  } clksrc_e;

  typedef struct packed {
    pmode_e  mode;
    clksrc_e sel;
    logic    xtal_en;
    logic    pll_en;
  } ctl_t;

  localparam int NUM_SRC = 2;  // startup timers: 0 crystal, 1 PLL

endpackage

// File: rtl/pcc_startup_timer.sv
module pcc_startup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ready,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  // Cleared while not running, so the first running cycle sees zero.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (ready || (cnt >= limit));

endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
  import pcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_slow,
  input  logic req_normal,
  input  logic cpu_wfi,
  input  logic wake_irq,
  input  logic xtal_done,
  input  logic pll_done,
  output ctl_t ctl
);

  localparam ctl_t CTL_RESET = '{mode: M_DOZE, sel: SRC_LOSC, xtal_en: 1'b0, pll_en: 1'b0};

  ctl_t nxt;

  always_comb begin
    nxt = ctl;
    unique case (ctl.mode)
      M_SLEEP: begin
        if (wake_irq) nxt.mode = M_DOZE;
      end
      M_DOZE: begin
        if (req_slow || req_normal) begin
          nxt.mode    = M_XTAL_UP;
          nxt.xtal_en = 1'b1;
        end else if (cpu_wfi) begin
          nxt.mode = M_SLEEP;
        end
      end
      M_XTAL_UP: begin
        if (ctl.sel == SRC_XTAL) nxt.mode = M_SLOW;
        else if (xtal_done)      nxt.sel  = SRC_XTAL;
      end
      M_SLOW: begin
        if (req_normal) begin
          nxt.mode   = M_PLL_UP;
          nxt.pll_en = 1'b1;
        end else if (!req_slow) begin
          nxt.mode = M_LEAVE_XTAL;
        end
      end
      M_PLL_UP: begin
        if (ctl.sel == SRC_PLL) nxt.mode = M_NORMAL;
        else if (pll_done)      nxt.sel  = SRC_PLL;
      end
      M_NORMAL: begin
        if (!req_normal) nxt.mode = M_LEAVE_PLL;
      end
      M_LEAVE_PLL: begin
        if (ctl.sel == SRC_PLL) begin
          nxt.sel = SRC_XTAL;
        end else begin
          nxt.pll_en = 1'b0;
          nxt.mode   = M_SLOW;
        end
      end
      M_LEAVE_XTAL: begin
        if (ctl.sel == SRC_XTAL) begin
          nxt.sel = SRC_LOSC;
        end else begin
          nxt.xtal_en = 1'b0;
          nxt.mode    = M_DOZE;
        end
      end
      default: nxt = CTL_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= CTL_RESET;
    else     ctl <= nxt;
  end

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_slow,
  input  logic             req_normal,
  input  logic             cpu_wfi,
  input  logic             wake_irq,
  input  logic             xtal_ready,
  input  logic             pll_lock,
  input  logic [CNT_W-1:0] cfg_xtal_cnt,
  input  logic [CNT_W-1:0] cfg_pll_cnt,
  output logic [1:0]       clk_sel_o,
  output logic             xtal_en_o,
  output logic             pll_en_o,
  output logic [2:0]       mode_o
);

  ctl_t                          ctl;
  logic [NUM_SRC-1:0]            t_run;
  logic [NUM_SRC-1:0]            t_rdy;
  logic [NUM_SRC-1:0]            t_done;
  logic [NUM_SRC-1:0][CNT_W-1:0] t_lim;

  assign t_run = {ctl.mode == M_PLL_UP, ctl.mode == M_XTAL_UP};
  assign t_rdy = {pll_lock, xtal_ready};
  assign t_lim = {cfg_pll_cnt, cfg_xtal_cnt};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_timer
    pcc_startup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .run   (t_run[g]),
      .ready (t_rdy[g]),
      .limit (t_lim[g]),
      .done  (t_done[g])
    );
  end

  pcc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_slow   (req_slow),
    .req_normal (req_normal),
    .cpu_wfi    (cpu_wfi),
    .wake_irq   (wake_irq),
    .xtal_done  (t_done[0]),
    .pll_done   (t_done[1]),
    .ctl        (ctl)
  );

  assign clk_sel_o = ctl.sel;
  assign xtal_en_o = ctl.xtal_en;
  assign pll_en_o  = ctl.pll_en;
  assign mode_o    = ctl.mode;

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_slow,
  input logic             req_normal,
  input logic             cpu_wfi,
  input logic             wake_irq,
  input logic [CNT_W-1:0] cfg_xtal_cnt,
  input logic [CNT_W-1:0] cfg_pll_cnt,
  input logic [1:0]       clk_sel_o,
  input logic             xtal_en_o,
  input logic             pll_en_o,
  input logic [2:0]       mode_o
);

  localparam logic [2:0] MD_SLEEP = 3'd0;
  localparam logic [2:0] MD_DOZE  = 3'd1;
  localparam logic [2:0] MD_XUP   = 3'd4;
  localparam logic [2:0] MD_PUP   = 3'd5;

  logic [CNT_W:0] dwell_x;
  logic [CNT_W:0] dwell_p;

  always_ff @(posedge clk) begin
    if (rst || mode_o != MD_XUP) dwell_x <= '0;
    else if (dwell_x != '1)      dwell_x <= dwell_x + 1'b1;
    if (rst || mode_o != MD_PUP) dwell_p <= '0;
    else if (dwell_p != '1)      dwell_p <= dwell_p + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode_o == MD_DOZE && clk_sel_o == 2'd0 && !xtal_en_o && !pll_en_o));

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_SLEEP && $past(mode_o) != MD_SLEEP) |->
      ($past(mode_o) == MD_DOZE && !$past(req_slow) && !$past(req_normal) && $past(cpu_wfi)));

  p_sleep_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_SLEEP && !wake_irq) |=> (mode_o == MD_SLEEP && $stable(clk_sel_o)));

  p_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_SLEEP && wake_irq) |=> mode_o == MD_DOZE);

  p_xtal_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_XUP) |-> (dwell_x <= ({1'b0, cfg_xtal_cnt} + 1'b1)));

  p_pll_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_PUP) |-> (dwell_p <= ({1'b0, cfg_pll_cnt} + 1'b1)));

  p_sel_in_transit_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_sel_o) |-> mode_o[2]);

  p_sel_apart_from_en_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_sel_o) |-> ($stable(xtal_en_o) && $stable(pll_en_o)));

  p_pll_sel_enabled_r10: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_o == 2'd2) |-> (pll_en_o && xtal_en_o));

  p_xtal_sel_enabled_r10: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_o == 2'd1) |-> xtal_en_o);

endmodule

bind pwr_clk_ctrl pcc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_slow     (req_slow),
  .req_normal   (req_normal),
  .cpu_wfi      (cpu_wfi),
  .wake_irq     (wake_irq),
  .cfg_xtal_cnt (cfg_xtal_cnt),
  .cfg_pll_cnt  (cfg_pll_cnt),
  .clk_sel_o    (clk_sel_o),
  .xtal_en_o    (xtal_en_o),
  .pll_en_o     (pll_en_o),
  .mode_o       (mode_o)
);

// File: tb/pwr_clk_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_tb;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_slow = 1'b0, req_normal = 1'b0, cpu_wfi = 1'b0, wake_irq = 1'b0;
  logic xtal_ready = 1'b0, pll_lock = 1'b0;
  logic [CNT_W-1:0] cfg_xtal_cnt = '0, cfg_pll_cnt = '0;
  logic [1:0] clk_sel_o;
  logic xtal_en_o, pll_en_o;
  logic [2:0] mode_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_clk_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_slow(req_slow), .req_normal(req_normal),
    .cpu_wfi(cpu_wfi), .wake_irq(wake_irq), .xtal_ready(xtal_ready),
    .pll_lock(pll_lock), .cfg_xtal_cnt(cfg_xtal_cnt), .cfg_pll_cnt(cfg_pll_cnt),
    .clk_sel_o(clk_sel_o), .xtal_en_o(xtal_en_o), .pll_en_o(pll_en_o),
    .mode_o(mode_o)
  );

  // packed view {mode, sel, xtal_en, pll_en}
  function automatic int st();
    return int'({mode_o, clk_sel_o, xtal_en_o, pll_en_o});
  endfunction

  function automatic int ex(int m, int s, int x, int p);
    return (m << 4) | (s << 2) | (x << 1) | p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // From DOZE: request, run crystal startup, land in SLOW (R4, R5)
  task automatic enter_slow(input bit via_normal, input int ready_after, input int exp_n);
    int n;
    if (via_normal) req_normal = 1'b1; else req_slow = 1'b1;
    tick();
    chk("R4 enter crystal startup", st(), ex(4, 0, 1, 0));
    n = 0;
    while (clk_sel_o != 2'd1 && n < 300) begin
      if (n == ready_after) xtal_ready = 1'b1;
      tick();
      n++;
    end
    chk("R5 clocks to crystal select", n, exp_n);
    xtal_ready = 1'b0;
    tick();
    chk("R5 settle in SLOW", st(), ex(2, 1, 1, 0));
  endtask

  // From SLOW: request NORMAL, run PLL startup (R6)
  task automatic enter_normal(input int ready_after, input int exp_n);
    int n;
    req_normal = 1'b1;
    tick();
    chk("R6 enter PLL startup", st(), ex(5, 1, 1, 1));
    n = 0;
    while (clk_sel_o != 2'd2 && n < 300) begin
      if (n == ready_after) pll_lock = 1'b1;
      tick();
      n++;
    end
    chk("R6 clocks to PLL select", n, exp_n);
    pll_lock = 1'b0;
    tick();
    chk("R6 settle in NORMAL", st(), ex(3, 2, 1, 1));
  endtask

  task automatic leave_normal();
    req_normal = 1'b0;
    tick();
    chk("R8 leave-PLL entry", st(), ex(6, 2, 1, 1));
    tick();
    chk("R8 select back to crystal", st(), ex(6, 1, 1, 1));
    tick();
    chk("R8 PLL off, SLOW", st(), ex(2, 1, 1, 0));
  endtask

  task automatic leave_slow();
    req_slow = 1'b0;
    req_normal = 1'b0;
    tick();
    chk("R7 leave-crystal entry", st(), ex(7, 1, 1, 0));
    tick();
    chk("R7 select to low-speed", st(), ex(7, 0, 1, 0));
    tick();
    chk("R7 crystal off, DOZE", st(), ex(1, 0, 0, 0));
  endtask

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset state", st(), ex(1, 0, 0, 0));

    // R5: crystal count sweep without ready
    for (int l = 0; l <= 5; l++) begin
      cfg_xtal_cnt = CNT_W'(l);
      enter_slow(1'b0, -1, l + 1);
      leave_slow();
    end
    // R5: ready arrives before a large count
    cfg_xtal_cnt = CNT_W'(10);
    for (int k = 0; k <= 3; k++) begin
      enter_slow(1'b0, k, k + 1);
      leave_slow();
    end

    // R6/R8: PLL count sweep, then ready variants
    cfg_xtal_cnt = CNT_W'(2);
    for (int l = 0; l <= 4; l++) begin
      cfg_pll_cnt = CNT_W'(l);
      enter_slow(1'b0, -1, 3);
      enter_normal(-1, l + 1);
      leave_normal();
      leave_slow();
    end
    cfg_pll_cnt = CNT_W'(12);
    for (int k = 0; k <= 3; k++) begin
      enter_slow(1'b0, -1, 3);
      enter_normal(k, k + 1);
      leave_normal();
      leave_slow();
    end

    // R6: NORMAL alone from DOZE passes through SLOW; leaving ends in DOZE
    enter_slow(1'b1, -1, 3);
    enter_normal(-1, 13);
    leave_normal();
    leave_slow();

    // R2: request wins over wait-for-interrupt in DOZE
    cpu_wfi = 1'b1;
    enter_slow(1'b0, 0, 1);
    // R2: SLOW with WFI and no request goes to leave-crystal, not SLEEP
    leave_slow();
    tick();
    chk("R2 DOZE to SLEEP on WFI", st(), ex(0, 0, 0, 0));

    // R3: requests ignored while sleeping
    req_slow = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 requests ignored in SLEEP", st(), ex(0, 0, 0, 0));
    end
    wake_irq = 1'b1;
    tick();
    wake_irq = 1'b0;
    chk("R3 wake to DOZE", st(), ex(1, 0, 0, 0));
    enter_slow(1'b0, -1, 3);
    cpu_wfi = 1'b0;
    leave_slow();
    tick();
    chk("R2 DOZE holds without WFI", st(), ex(1, 0, 0, 0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule